// File: doc/BRIEF.md
# USB OTG Interrupt Wrapper

This block sits between a USB On-The-Go controller core and the processor. It latches interrupt events from the core into two groups: an endpoint group with one bit per transmit and per receive endpoint, and a core group with nine USB event bits. The top bit of the core group is the VBUS-drive event. Each group has a sticky source word, set and clear aliases for it, a mask word with its own set and clear aliases, and a read-only masked view. The result is one level interrupt line to the processor.

The line rises when either group has a masked source pending and the wrapper is armed. Once the line has been taken, the wrapper disarms. It does not raise the line again until software writes the end-of-interrupt word, even if further sources are pending. The register file also holds a nonzero revision word, a control word whose bit 0 drives a soft reset to the controller, a status word that reports the live VBUS-drive level, and three plain configuration words.

Software reaches everything over a 32-bit single-cycle bus with word addresses. Word index n corresponds to byte offset 4*n.

Top module: `usb_irq_wrap`

## Requirements
- R1: After reset, word 0 (byte 0x00) reads the nonzero parameter REV_ID. Writes to it are ignored.
- R2: Bit 0 of word 1 (0x04) is stored and drives `soft_rst`, and its other bits read 0. Bit 0 of word 2 (0x08) reads the present level of `vbus_drv`, and its other bits read 0.
- R3: Endpoint source (word 8, 0x20) bits latch on a pulse of `ep_tx_evt[i]` (bit i) or `ep_rx_evt[j]` (bit 17+j), or on a 1 written to the set alias (word 9, 0x24). Bit 16 never sets.
- R4: A 1 written to a source clear alias (endpoint word 10 at 0x28, core word 18 at 0x48) clears that bit. If an event pulse for a bit arrives in the same cycle as its clear, the bit ends up set.
- R5: Core source (word 16, 0x40) uses only bits 24:16. `core_evt[k]` sets bit 16+k, and bit 24 is the VBUS-drive event. Software can force any of these bits by writing 1 to the set alias (word 17, 0x44).
- R6: The mask words (endpoint word 11 at 0x2C, core word 19 at 0x4C) load on a direct write. Their set aliases (words 12 and 20) OR bits in, and their clear aliases (words 13 and 21) remove bits. The masked words (14 at 0x38, 22 at 0x58) read source AND mask.
- R7: `irq` rises one cycle after a masked source becomes pending while the wrapper is armed. It stays high while anything masked is pending, and it falls one cycle after nothing masked is pending.
- R8: After `irq` has risen, it does not rise again until any value is written to word 24 (0x60). The cycle after that write, a pending masked source raises it again.
- R9: Reads of set and clear aliases return the underlying source or mask. Source and masked words are read-only. Reserved words (3, 4, 23 and all unlisted indices) read 0, and writes to them change nothing.
- R10: Words 5, 6 and 7 (0x14, 0x18, 0x1C) are 32-bit storage registers that read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ep_tx_evt | input | EP_TX_N | Transmit endpoint event pulses (endpoint 0 upward) |
| ep_rx_evt | input | EP_RX_N | Receive endpoint event pulses (endpoint 1 upward) |
| core_evt | input | CORE_N | Core USB event pulses; the top bit is the VBUS-drive event |
| vbus_drv | input | 1 | Present VBUS-drive level |
| soft_rst | output | 1 | Soft reset to the controller core |
| irq | output | 1 | Level interrupt to the processor |

## Verification
The bench uses the default parameters: 16 transmit bits, 15 receive bits starting above an unused bit 16, nine core bits at 16, and a 5-bit word address. With these values the unused bit 16 and the top receive bit 31 can be reached by an all-ones write to the set alias. The VBUS-drive bit at 24 can be forced through the core set alias. The end-of-interrupt word at index 24 can be reached within the address range. Reserved indices on both sides of the group banks can also be probed.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  // Word indices of the register map (byte offset / 4)
  localparam int W_REV       = 0;
  localparam int W_CTRL      = 1;
  localparam int W_STAT      = 2;
  localparam int W_AUTOREQ   = 5;
  localparam int W_SRPTIME   = 6;
  localparam int W_TEARDOWN  = 7;
  localparam int W_EP_BASE   = 8;
  localparam int W_CORE_BASE = 16;
  localparam int W_EOI       = 24;

  // Offsets within a group bank
  localparam int G_SRC    = 0;
  localparam int G_SET    = 1;
  localparam int G_CLR    = 2;
  localparam int G_MSK    = 3;
  localparam int G_MSET   = 4;
  localparam int G_MCLR   = 5;
  localparam int G_MASKED = 6;

  // Contiguous field of n ones starting at bit lo
  function automatic logic [31:0] field_ones(input int lo, input int n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++)
      if (i >= lo && i < lo + n) r[i] = 1'b1;
    return r;
  endfunction

  // Next value of a sticky source: set and events win over clear
  function automatic logic [31:0] sticky_next(input logic [31:0] cur,
      input logic [31:0] setv, input logic [31:0] clrv, input logic [31:0] valid);
    return ((cur & ~clrv) | setv) & valid;
  endfunction
endpackage

// File: rtl/usb_irq_bank.sv
module usb_irq_bank
  import usb_irq_pkg::*;
#(
  parameter logic [31:0] VALID = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt,
  input  logic        src_set_we,
  input  logic        src_clr_we,
  input  logic        msk_we,
  input  logic        msk_set_we,
  input  logic        msk_clr_we,
  input  logic [31:0] wdata,
  output logic [31:0] src,
  output logic [31:0] msk,
  output logic [31:0] masked
);
  logic [31:0] set_vec, clr_vec, mset_vec, mclr_vec;

  assign set_vec  = (src_set_we ? wdata : 32'h0) | evt;
  assign clr_vec  = src_clr_we ? wdata : 32'h0;
  assign mset_vec = msk_set_we ? wdata : 32'h0;
  assign mclr_vec = msk_clr_we ? wdata : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      msk <= '0;
    end else begin
      src <= sticky_next(src, set_vec, clr_vec, VALID);
      if (msk_we) msk <= wdata & VALID;
      else        msk <= sticky_next(msk, mset_vec, mclr_vec, VALID);
    end
  end

  assign masked = src & msk;
endmodule

// File: rtl/usb_irq_line.sv
module usb_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic eoi_wr,
  output logic armed,
  output logic irq
);
  logic line_d;

  assign line_d = pending & (armed | irq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
      irq   <= 1'b0;
    end else begin
      irq   <= line_d;
      armed <= eoi_wr | (armed & ~line_d);
    end
  end
endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
  import usb_irq_pkg::*;
#(
  parameter int          ADDR_W     = 5,
  parameter int          EP_TX_N    = 16,
  parameter int          EP_RX_N    = 15,
  parameter int          RX_SHIFT   = 16,
  parameter int          CORE_N     = 9,
  parameter int          CORE_SHIFT = 16,
  parameter logic [31:0] REV_ID     = 32'h0002_0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [EP_TX_N-1:0] ep_tx_evt,
  input  logic [EP_RX_N-1:0] ep_rx_evt,
  input  logic [CORE_N-1:0]  core_evt,
  input  logic               vbus_drv,
  output logic               soft_rst,
  output logic               irq
);
  localparam logic [31:0] EP_VALID   = field_ones(0, EP_TX_N) | field_ones(RX_SHIFT + 1, EP_RX_N);
  localparam logic [31:0] CORE_VALID = field_ones(CORE_SHIFT, CORE_N);

  logic [31:0] ep_evt_w, core_evt_w;
  logic [31:0] ep_src, ep_mask, ep_masked;
  logic [31:0] core_src, core_mask, core_masked;
  logic [31:0] auto_q, srp_q, tdn_q;
  logic        ctrl_q;
  logic        pending, armed, eoi_wr;
  int          a;

  assign a = int'(bus_addr);

  // Place event pulses into the group words
  always_comb begin
    ep_evt_w   = '0;
    core_evt_w = '0;
    for (int i = 0; i < EP_TX_N; i++) ep_evt_w[i] = ep_tx_evt[i];
    for (int j = 0; j < EP_RX_N; j++) ep_evt_w[RX_SHIFT + 1 + j] = ep_rx_evt[j];
    for (int k = 0; k < CORE_N; k++) core_evt_w[CORE_SHIFT + k] = core_evt[k];
  end

  usb_irq_bank #(.VALID(EP_VALID)) u_ep (
    .clk(clk), .rst_n(rst_n), .evt(ep_evt_w),
    .src_set_we(bus_we && a == W_EP_BASE + G_SET),
    .src_clr_we(bus_we && a == W_EP_BASE + G_CLR),
    .msk_we    (bus_we && a == W_EP_BASE + G_MSK),
    .msk_set_we(bus_we && a == W_EP_BASE + G_MSET),
    .msk_clr_we(bus_we && a == W_EP_BASE + G_MCLR),
    .wdata(bus_wdata), .src(ep_src), .msk(ep_mask), .masked(ep_masked)
  );

  usb_irq_bank #(.VALID(CORE_VALID)) u_core (
    .clk(clk), .rst_n(rst_n), .evt(core_evt_w),
    .src_set_we(bus_we && a == W_CORE_BASE + G_SET),
    .src_clr_we(bus_we && a == W_CORE_BASE + G_CLR),
    .msk_we    (bus_we && a == W_CORE_BASE + G_MSK),
    .msk_set_we(bus_we && a == W_CORE_BASE + G_MSET),
    .msk_clr_we(bus_we && a == W_CORE_BASE + G_MCLR),
    .wdata(bus_wdata), .src(core_src), .msk(core_mask), .masked(core_masked)
  );

  assign pending = (|ep_masked) | (|core_masked);
  assign eoi_wr  = bus_we && a == W_EOI;

  usb_irq_line u_line (
    .clk(clk), .rst_n(rst_n), .pending(pending), .eoi_wr(eoi_wr),
    .armed(armed), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
      auto_q <= '0;
      srp_q  <= '0;
      tdn_q  <= '0;
    end else if (bus_we) begin
      case (a)
        W_CTRL:     ctrl_q <= bus_wdata[0];
        W_AUTOREQ:  auto_q <= bus_wdata;
        W_SRPTIME:  srp_q  <= bus_wdata;
        W_TEARDOWN: tdn_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign soft_rst = ctrl_q;

  always_comb begin
    case (a)
      W_REV:                                       bus_rdata = REV_ID;
      W_CTRL:                                      bus_rdata = {31'h0, ctrl_q};
      W_STAT:                                      bus_rdata = {31'h0, vbus_drv};
      W_AUTOREQ:                                   bus_rdata = auto_q;
      W_SRPTIME:                                   bus_rdata = srp_q;
      W_TEARDOWN:                                  bus_rdata = tdn_q;
      W_EP_BASE + G_SRC, W_EP_BASE + G_SET,
      W_EP_BASE + G_CLR:                           bus_rdata = ep_src;
      W_EP_BASE + G_MSK, W_EP_BASE + G_MSET,
      W_EP_BASE + G_MCLR:                          bus_rdata = ep_mask;
      W_EP_BASE + G_MASKED:                        bus_rdata = ep_masked;
      W_CORE_BASE + G_SRC, W_CORE_BASE + G_SET,
      W_CORE_BASE + G_CLR:                         bus_rdata = core_src;
      W_CORE_BASE + G_MSK, W_CORE_BASE + G_MSET,
      W_CORE_BASE + G_MCLR:                        bus_rdata = core_mask;
      W_CORE_BASE + G_MASKED:                      bus_rdata = core_masked;
      default:                                     bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/usb_irq_wrap_chk.sv
module usb_irq_wrap_chk
  import usb_irq_pkg::*;
#(
  parameter int          ADDR_W   = 5,
  parameter logic [31:0] EP_VALID = 32'hFFFE_FFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       ep_evt_w,
  input logic [31:0]       ep_src,
  input logic [31:0]       ep_mask,
  input logic [31:0]       core_mask,
  input logic              vbus_drv,
  input logic              pending,
  input logic              armed,
  input logic              eoi_wr,
  input logic              irq
);
  logic wr_set, wr_clr, wr_rsv, rd_stat;
  assign wr_set  = bus_we && int'(bus_addr) == W_EP_BASE + G_SET;
  assign wr_clr  = bus_we && int'(bus_addr) == W_EP_BASE + G_CLR;
  assign wr_rsv  = bus_we && int'(bus_addr) == 4;
  assign rd_stat = int'(bus_addr) == W_STAT;

  AST_STATUS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> bus_rdata[0] == vbus_drv); // R2

  AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((ep_src & $past(bus_wdata) & EP_VALID) == ($past(bus_wdata) & EP_VALID))); // R3

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && ep_evt_w == 32'h0) |=> ((ep_src & $past(bus_wdata)) == 32'h0)); // R4

  AST_LINE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(pending)); // R7

  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !eoi_wr) |=> !$rose(irq)); // R8

  AST_RESERVED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rsv |=> ($stable(ep_mask) && $stable(core_mask))); // R9
endmodule

bind usb_irq_wrap usb_irq_wrap_chk #(.ADDR_W(ADDR_W), .EP_VALID(EP_VALID)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep_evt_w(ep_evt_w),
  .ep_src(ep_src), .ep_mask(ep_mask), .core_mask(core_mask),
  .vbus_drv(vbus_drv), .pending(pending), .armed(armed),
  .eoi_wr(eoi_wr), .irq(irq)
);

// File: tb/usb_irq_wrap_test.sv
module usb_irq_wrap_test;
  localparam logic [31:0] REV = 32'h0002_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] ep_tx_evt = '0;
  logic [14:0] ep_rx_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        vbus_drv = 1'b0;
  logic        soft_rst, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_irq_wrap #(.REV_ID(REV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep_tx_evt(ep_tx_evt),
    .ep_rx_evt(ep_rx_evt), .core_evt(core_evt), .vbus_drv(vbus_drv),
    .soft_rst(soft_rst), .irq(irq)
  );

  // {req[3:0], write word[4:0], wdata[31:0], read word[4:0], expected[31:0]}
  localparam int NV = 18;
  localparam logic [77:0] VECS [NV] = '{
    {4'd6,  5'd11, 32'h0000_00FF, 5'd11, 32'h0000_00FF}, // R6 mask direct
    {4'd6,  5'd12, 32'h0000_0F00, 5'd13, 32'h0000_0FFF}, // R6 mask set, read via alias
    {4'd6,  5'd13, 32'h0000_000F, 5'd11, 32'h0000_0FF0}, // R6 mask clear
    {4'd3,  5'd9,  32'hFFFF_FFFF, 5'd8,  32'hFFFE_FFFF}, // R3 bit 16 dead
    {4'd4,  5'd10, 32'hFFFF_0000, 5'd10, 32'h0000_FFFF}, // R4 clear upper
    {4'd6,  5'd11, 32'h0000_00F0, 5'd14, 32'h0000_00F0}, // R6 masked view
    {4'd4,  5'd10, 32'hFFFF_FFFF, 5'd14, 32'h0000_0000}, // R4 clear all
    {4'd5,  5'd17, 32'hFFFF_FFFF, 5'd16, 32'h01FF_0000}, // R5 core field only
    {4'd6,  5'd19, 32'h0100_0000, 5'd22, 32'h0100_0000}, // R6 core masked
    {4'd4,  5'd18, 32'hFEFF_FFFF, 5'd16, 32'h0100_0000}, // R4 core clear
    {4'd9,  5'd18, 32'hFFFF_FFFF, 5'd20, 32'h0100_0000}, // R9 mask-set alias read
    {4'd10, 5'd5,  32'h1234_5678, 5'd5,  32'h1234_5678}, // R10
    {4'd10, 5'd6,  32'h0000_ABCD, 5'd6,  32'h0000_ABCD}, // R10
    {4'd10, 5'd7,  32'h8000_0001, 5'd7,  32'h8000_0001}, // R10
    {4'd9,  5'd4,  32'hFFFF_FFFF, 5'd4,  32'h0000_0000}, // R9 reserved read
    {4'd9,  5'd23, 32'hFFFF_FFFF, 5'd11, 32'h0000_00F0}, // R9 reserved write inert
    {4'd9,  5'd8,  32'hFFFF_FFFF, 5'd8,  32'h0000_0000}, // R9 source read-only
    {4'd9,  5'd14, 32'hFFFF_FFFF, 5'd14, 32'h0000_0000}  // R9 masked read-only
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] wa, input logic [31:0] wd);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = wa; bus_wdata = wd;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] ra, output logic [31:0] v);
    bus_addr = ra;
    #1;
    v = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    wr(5'd11, 32'h0); wr(5'd19, 32'h0);
    wr(5'd10, 32'hFFFF_FFFF); wr(5'd18, 32'hFFFF_FFFF);
    tick();
    wr(5'd24, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // Reset state
    chk("R7 reset irq", {31'h0, irq}, 32'h0);
    chk("R2 reset soft_rst", {31'h0, soft_rst}, 32'h0);
    rd(5'd0, v);  chk("R1 revision", v, REV);
    wr(5'd0, 32'h0);
    rd(5'd0, v);  chk("R1 revision after write", v, REV);
    rd(5'd8, v);  chk("R3 reset source", v, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [77:0] e;
      e = VECS[i];
      wr(e[73:69], e[68:37]);
      rd(e[36:32], v);
      chk($sformatf("R%0d vector %0d", e[77:74], i), v, e[31:0]);
    end

    quiet();

    // R2 control and status
    wr(5'd1, 32'hFFFF_FFFF);
    chk("R2 soft_rst on", {31'h0, soft_rst}, 32'h1);
    rd(5'd1, v); chk("R2 control readback", v, 32'h1);
    wr(5'd1, 32'h0);
    chk("R2 soft_rst off", {31'h0, soft_rst}, 32'h0);
    vbus_drv = 1'b1;
    rd(5'd2, v); chk("R2 status high", v, 32'h1);
    vbus_drv = 1'b0;
    rd(5'd2, v); chk("R2 status low", v, 32'h0);

    // R3 event pulses, top receive bit
    @(negedge clk); ep_tx_evt[5] = 1'b1; ep_rx_evt[14] = 1'b1;
    @(negedge clk); ep_tx_evt = '0; ep_rx_evt = '0;
    rd(5'd8, v); chk("R3 event latch", v, 32'h8000_0020);

    // R4 event beats clear in the same cycle
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'd10; bus_wdata = 32'h8000_0028; ep_tx_evt[3] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; ep_tx_evt = '0;
    rd(5'd8, v); chk("R4 set wins", v, 32'h0000_0008);
    wr(5'd10, 32'hFFFF_FFFF);

    // R5 core event pulses, VBUS-drive bit
    @(negedge clk); core_evt = 9'h101;
    @(negedge clk); core_evt = '0;
    rd(5'd16, v); chk("R5 core event latch", v, 32'h0101_0000);
    wr(5'd18, 32'hFFFF_FFFF);

    // R7 line timing
    wr(5'd12, 32'h0000_0001);
    @(negedge clk); ep_tx_evt[0] = 1'b1;
    @(negedge clk); ep_tx_evt = '0;
    chk("R7 not yet", {31'h0, irq}, 32'h0);
    tick();
    chk("R7 rises", {31'h0, irq}, 32'h1);
    wr(5'd10, 32'h0000_0001);
    chk("R7 held one cycle", {31'h0, irq}, 32'h1);
    tick();
    chk("R7 falls", {31'h0, irq}, 32'h0);

    // R8 no refire without end-of-interrupt
    @(negedge clk); ep_tx_evt[0] = 1'b1;
    @(negedge clk); ep_tx_evt = '0;
    repeat (3) tick();
    chk("R8 stays low", {31'h0, irq}, 32'h0);
    wr(5'd24, 32'hDEAD_BEEF);
    chk("R8 eoi cycle", {31'h0, irq}, 32'h0);
    tick();
    chk("R8 rearmed", {31'h0, irq}, 32'h1);
    rd(5'd24, v); chk("R9 eoi reads zero", v, 32'h0);

    quiet();

    // R5 forced VBUS-drive event through core set alias
    wr(5'd20, 32'h0100_0000);
    wr(5'd17, 32'h0100_0000);
    chk("R5 forced not yet", {31'h0, irq}, 32'h0);
    tick();
    chk("R5 forced raises line", {31'h0, irq}, 32'h1);
    rd(5'd22, v); chk("R5 forced masked", v, 32'h0100_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule